// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block decides, for a single general-purpose pin, when an interrupt event has occurred and keeps a record of it. It takes the already-filtered pin level together with the control fields of that pin: trigger mode, a two-bit polarity code, interrupt enable, interrupt unmask and wake enable. Qualified events set a sticky interrupt status bit and, separately, a sticky wake status bit. The interrupt status drives a request output only while the pin is unmasked.

Software acknowledges an event by pulsing the clear strobe of a status bit. Each strobe stands for a write of 1 to that bit; a write of 0 is represented by the strobe staying low. In level mode a condition that is still present after a clear records itself again one cycle later. Enable and unmask are independent. Enable decides whether events are recorded. Unmask decides only whether the recorded status reaches the request line.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, interrupt status, wake status and the request output are all 0.
- R2: With trigger mode 0 (edge), polarity 01 records a rising edge, 00 a falling edge and 10 either edge. An edge is the current pin level differing from the level sampled one clock earlier. The status rises on the clock edge that follows the pin change.
- R3: With trigger mode 1 (level), polarity 01 records on every cycle the pin is high and 00 on every cycle it is low. The status therefore returns one cycle after a clear while the level persists.
- R4: Polarity 11 never records an event in either mode, and polarity 10 records nothing in level mode.
- R5: With interrupt enable at 0 no event is recorded in the interrupt status, and a status that is already set stays set.
- R6: The request output equals interrupt status AND unmask (1 = unmasked). Masking changes neither status bit.
- R7: A clear strobe of 1 on a status bit clears it at the next clock edge. While the strobe is 0 the bit holds its value.
- R8: The wake status records the same events as the interrupt status, gated by wake enable instead of interrupt enable. It has its own clear strobe.
- R9: When an event and a clear strobe for the same status bit occur in the same cycle, the bit ends up set.
- R10: The sampled previous level resets to 0, so a pin that is high in the first cycle after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_level_i | input | 1 | Filtered pin level |
| level_mode_i | input | 1 | Trigger mode: 0 edge, 1 level |
| polarity_i | input | 2 | 00 low/falling, 01 high/rising, 10 both edges, 11 reserved |
| irq_en_i | input | 1 | Interrupt enable (records into status) |
| irq_unmask_i | input | 1 | 1 lets the status drive the request |
| wake_en_i | input | 1 | Wake enable (records into wake status) |
| clr_irq_i | input | 1 | Write-1 clear strobe for interrupt status |
| clr_wake_i | input | 1 | Write-1 clear strobe for wake status |
| irq_sts_o | output | 1 | Sticky interrupt status |
| wake_sts_o | output | 1 | Sticky wake status |
| irq_req_o | output | 1 | Masked interrupt request |

## Verification
Two functions can land in the same cycle: recording a new event and the software clear of the same status bit. Directed steps raise a clear strobe in the very cycle of a rising edge, and also while a level condition persists. The random phase weights the clear strobes heavily, so that collisions with edges and levels occur many times. Each collision is judged by comparing the status after the next clock edge against a bench model in which the set overrides the clear.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int POL_W = 2;

  typedef enum logic [POL_W-1:0] {
    POL_LOW  = 2'b00,
    POL_HIGH = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } pol_e;

  typedef enum int {
    STS_IRQ  = 0,
    STS_WAKE = 1
  } sts_idx_e;

  localparam int NUM_STS = 2;
endpackage

// File: rtl/gpio_irq_edge.sv
`timescale 1ns/1ps
module gpio_irq_edge #(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_LEVEL;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/gpio_irq_match.sv
`timescale 1ns/1ps
module gpio_irq_match
  import gpio_irq_pkg::*;
(
  input  logic             level_mode_i,
  input  logic [POL_W-1:0] polarity_i,
  input  logic             level_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             event_o
);
  pol_e pol;
  assign pol = pol_e'(polarity_i);

  always_comb begin
    event_o = 1'b0;
    if (level_mode_i) begin
      unique case (pol)
        POL_HIGH: event_o = level_i;
        POL_LOW:  event_o = ~level_i;
        default:  event_o = 1'b0;  // both/reserved: no level meaning
      endcase
    end else begin
      unique case (pol)
        POL_HIGH: event_o = rise_i;
        POL_LOW:  event_o = fall_i;
        POL_BOTH: event_o = rise_i | fall_i;
        default:  event_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_sticky.sv
`timescale 1ns/1ps
module gpio_irq_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_q <= 1'b0;
    else if (set_i)  sts_q <= 1'b1;
    else if (clr_i)  sts_q <= 1'b0;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_level_i,
  input  logic             level_mode_i,
  input  logic [POL_W-1:0] polarity_i,
  input  logic             irq_en_i,
  input  logic             irq_unmask_i,
  input  logic             wake_en_i,
  input  logic             clr_irq_i,
  input  logic             clr_wake_i,
  output logic             irq_sts_o,
  output logic             wake_sts_o,
  output logic             irq_req_o
);
  logic rise, fall, evt;
  logic [NUM_STS-1:0] gate, clr, sts;

  gpio_irq_edge #(.RST_LEVEL(RST_LEVEL)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(pin_level_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  gpio_irq_match u_match (
    .level_mode_i(level_mode_i),
    .polarity_i  (polarity_i),
    .level_i     (pin_level_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .event_o     (evt)
  );

  assign gate[STS_IRQ]  = irq_en_i;
  assign gate[STS_WAKE] = wake_en_i;
  assign clr[STS_IRQ]   = clr_irq_i;
  assign clr[STS_WAKE]  = clr_wake_i;

  for (genvar g = 0; g < NUM_STS; g++) begin : g_sts
    gpio_irq_sticky u_sts (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt & gate[g]),
      .clr_i (clr[g]),
      .sts_o (sts[g])
    );
  end

  assign irq_sts_o  = sts[STS_IRQ];
  assign wake_sts_o = sts[STS_WAKE];
  assign irq_req_o  = sts[STS_IRQ] & irq_unmask_i;
endmodule

// File: rtl/gpio_irq_detect_chk.sv
`timescale 1ns/1ps
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pin_level_i,
  input logic             level_mode_i,
  input logic [POL_W-1:0] polarity_i,
  input logic             irq_en_i,
  input logic             irq_unmask_i,
  input logic             wake_en_i,
  input logic             clr_irq_i,
  input logic             clr_wake_i,
  input logic             irq_sts_o,
  input logic             wake_sts_o,
  input logic             irq_req_o
);
  // R6
  req_needs_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_sts_o && irq_unmask_i));

  // R4
  rsvd_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (polarity_i == 2'b11 && !irq_sts_o) |=> !irq_sts_o);

  // R5
  disabled_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i && !irq_sts_o) |=> !irq_sts_o);

  // R7
  hold_without_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_sts_o && !clr_irq_i) |=> irq_sts_o);

  // R7
  clr_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_irq_i && !irq_en_i) |=> !irq_sts_o);

  // R3
  level_high_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && level_mode_i && polarity_i == 2'b01 && pin_level_i) |=> irq_sts_o);

  // R9
  level_low_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && level_mode_i && polarity_i == 2'b00 && !pin_level_i && clr_irq_i) |=> irq_sts_o);

  // R8
  wake_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_en_i && !wake_sts_o) |=> !wake_sts_o);

  // R8
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_sts_o && !clr_wake_i) |=> wake_sts_o);
endmodule

bind gpio_irq_detect gpio_irq_detect_chk u_chk (.*);

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/1ps
module gpio_irq_detect_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, lvl_mode = 1'b0, en = 1'b0, unmask = 1'b0, wen = 1'b0;
  logic cl_irq = 1'b0, cl_wake = 1'b0;
  logic [1:0] pol = 2'b01;
  logic irq_sts, wake_sts, irq_req;

  int checks = 0, fails = 0;
  logic m_prev = 1'b0, m_irq = 1'b0, m_wake = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_detect u_gpio_irq_detect (
    .clk_i(clk), .rst_ni(rst_n), .pin_level_i(pin), .level_mode_i(lvl_mode),
    .polarity_i(pol), .irq_en_i(en), .irq_unmask_i(unmask), .wake_en_i(wen),
    .clr_irq_i(cl_irq), .clr_wake_i(cl_wake),
    .irq_sts_o(irq_sts), .wake_sts_o(wake_sts), .irq_req_o(irq_req)
  );

  function automatic logic ev_fn(logic mode, logic [1:0] p, logic cur, logic prv);
    if (mode) return (p == 2'b01) ? cur : (p == 2'b00) ? ~cur : 1'b0;
    case (p)
      2'b01:   return cur & ~prv;
      2'b00:   return ~cur & prv;
      2'b10:   return cur ^ prv;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // inputs already applied at negedge; advance one clock and compare
  task automatic step(string tag);
    logic e;
    e = ev_fn(lvl_mode, pol, pin, m_prev);
    m_irq  = (e & en)  | (m_irq  & ~cl_irq);
    m_wake = (e & wen) | (m_wake & ~cl_wake);
    m_prev = pin;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " irq_sts"}, irq_sts, m_irq);
    chk({tag, " wake_sts"}, wake_sts, m_wake);
    chk({tag, " irq_req"}, irq_req, m_irq & unmask);
    cl_irq = 1'b0;
    cl_wake = 1'b0;
  endtask

  task automatic clear_all(string tag);
    cl_irq = 1'b1; cl_wake = 1'b1; en = 1'b0; wen = 1'b0;
    step(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq_sts", irq_sts, 1'b0);
    chk("R1 wake_sts", wake_sts, 1'b0);
    chk("R1 irq_req", irq_req, 1'b0);
    rst_n = 1'b1;

    // R10 pin high right after reset is a rising edge
    pin = 1'b1; en = 1'b1; unmask = 1'b1; pol = 2'b01;
    step("R10 first-cycle rise");
    chk("R10 set", irq_sts, 1'b1);
    clear_all("R7 clear");
    chk("R7 cleared", irq_sts, 1'b0);

    // R2 falling / both edges
    en = 1'b1; pol = 2'b00; pin = 1'b0;
    step("R2 falling");
    chk("R2 fall set", irq_sts, 1'b1);
    step("R7 hold without clear");
    clear_all("R7 clear2");
    en = 1'b1; pol = 2'b10; pin = 1'b1;
    step("R2 both rise");
    clear_all("R2 clr");
    en = 1'b1; pol = 2'b10; pin = 1'b1;
    step("R2 steady no edge");
    chk("R2 no edge", irq_sts, 1'b0);
    pin = 1'b0;
    step("R2 both fall");

    // R9 set wins with a same-cycle clear
    pol = 2'b01; pin = 1'b1; cl_irq = 1'b1;
    step("R9 edge vs clear");
    chk("R9 set wins", irq_sts, 1'b1);

    // R3 level mode re-asserts after clear
    lvl_mode = 1'b1; pol = 2'b01; cl_irq = 1'b1;
    step("R3 level persists");
    chk("R3 still set", irq_sts, 1'b1);
    en = 1'b0; cl_irq = 1'b1;
    step("R5 clear while disabled");
    en = 1'b1;
    step("R3 level re-set");
    chk("R3 re-set", irq_sts, 1'b1);

    // R6 masking leaves status alone
    unmask = 1'b0;
    step("R6 masked");
    chk("R6 req low", irq_req, 1'b0);
    chk("R6 sts kept", irq_sts, 1'b1);
    unmask = 1'b1;

    // R4 reserved code and level+both
    clear_all("R4 prep");
    en = 1'b1; pol = 2'b10; pin = 1'b1;
    step("R4 level both");
    chk("R4 level both none", irq_sts, 1'b0);
    lvl_mode = 1'b0; pol = 2'b11; pin = 1'b0;
    step("R4 reserved fall");
    pin = 1'b1;
    step("R4 reserved rise");
    chk("R4 reserved none", irq_sts, 1'b0);

    // R5 disabled: no record, held status kept
    en = 1'b0; pol = 2'b00; pin = 1'b0;
    step("R5 disabled edge");
    chk("R5 none", irq_sts, 1'b0);

    // R8 wake independent of irq enable
    wen = 1'b1; pin = 1'b1; pol = 2'b01;
    step("R8 wake set");
    chk("R8 wake", wake_sts, 1'b1);
    chk("R8 irq untouched", irq_sts, 1'b0);
    cl_wake = 1'b1; wen = 1'b0;
    step("R8 wake clear");
    chk("R8 wake cleared", wake_sts, 1'b0);

    // random phase (R2 R3 R7 R9 collisions)
    for (int i = 0; i < 3000; i++) begin
      pin      = 1'($urandom_range(0, 1));
      lvl_mode = ($urandom_range(0, 3) == 0);
      pol      = 2'($urandom_range(0, 3));
      en       = ($urandom_range(0, 3) != 0);
      wen      = 1'($urandom_range(0, 1));
      unmask   = 1'($urandom_range(0, 1));
      cl_irq   = ($urandom_range(0, 2) == 0);
      cl_wake  = ($urandom_range(0, 2) == 0);
      step("R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule